// File: doc/BRIEF.md
# Timer Match Output Controller

This block sits beside a free-running timer counter and turns counter matches into four output levels. On every clock it compares the counter value it is given with four match values. When channel n's match value equals the counter, that channel's output is changed according to the 2-bit action code programmed for that channel. The code can clear the output, set it, invert it, or leave it unchanged.

Software reaches the block through one 16-bit control/status word with a plain write strobe and a continuously driven read value. The word shows the live level of all four outputs and the four action codes. Software may also load the output levels directly by writing the word.

The counter and the match values come in as ports. Counting, match-driven counter reset or stop, interrupts and pin routing belong to neighbouring logic.

Top module: `match_output_ctrl`

## Requirements
- R1: With `rst_n` low at a rising clock edge, all four output levels and all four action codes become 0, so `match_out` = 0 and `reg_rdata` = 16'h0000 after that edge.
- R2: `reg_rdata[3:0]` always equals `match_out[3:0]`, bit n being the level of channel n.
- R3: Action codes sit at `reg_rdata[5:4]` (channel 0), `[7:6]` (channel 1), `[9:8]` (channel 2) and `[11:10]` (channel 3). A write loads them from the same bits of `reg_wdata` at the next edge.
- R4: Action encoding when channel n matches: 2'b00 leaves the output unchanged, 2'b01 drives it to 0, 2'b10 drives it to 1, 2'b11 inverts it. The new level is visible one clock after the edge at which `count` equals the match value.
- R5: A match is acted on once per counter value. While `count` holds the matching value over several cycles, the action is applied only in the first of those cycles. Moving away and returning makes a new match.
- R6: If a write and a match with a non-00 action hit the same channel in the same cycle, the match action decides that channel's new level. The match uses the action code and level held before the write.
- R7: Writes to `reg_wdata[15:12]` have no effect, and `reg_rdata[15:12]` always reads 0.
- R8: On a write with no acting match, `match_out[n]` takes `reg_wdata[n]` at the next edge.
- R9: Each channel compares only against its own match value and applies only its own action code. Matches on other channels do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| count | input | CNT_W | Current timer counter value |
| match_val | input | 4*CNT_W | Match values, channel n in bits [n*CNT_W +: CNT_W] |
| reg_we | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 16 | Write data for the control/status word |
| reg_rdata | output | 16 | Current control/status word |
| match_out | output | 4 | Output levels of channels 0 to 3 |

## Verification
Each result is due one clock edge after its stimulus. A write, a match, or a write colliding with a match changes `match_out` and `reg_rdata` at the first rising edge that samples it, because one register sits between input and output. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a period after the edge that updated them. For the held-counter case, the count is kept equal to the match value for several further cycles and the outputs are checked after each one, which confirms that nothing changes after the first cycle.

// File: rtl/match_output_pkg.sv
package match_output_pkg;

  localparam int NCH       = 4;
  localparam int REG_W     = 16;
  localparam int ACT_W     = 2;
  localparam int STATE_LSB = 0;
  localparam int ACT_LSB   = 4;
  localparam int RSVD_LSB  = ACT_LSB + NCH * ACT_W;
  localparam int RSVD_W    = REG_W - RSVD_LSB;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // Level after a match with the given action.
  function automatic logic apply_action(input act_e act, input logic cur);
    case (act)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TGL:  return ~cur;
      default:  return cur;
    endcase
  endfunction

  // Bit position of channel ch's action code in the control word.
  function automatic int act_pos(input int ch);
    return ACT_LSB + ch * ACT_W;
  endfunction

endpackage

// File: rtl/match_detect.sv
module match_detect
  import match_output_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   count,
  input  logic [NCH*CNT_W-1:0] match_val,
  output logic [NCH-1:0]     fire
);

  logic [CNT_W-1:0] count_q;
  logic             count_same;
  logic [NCH-1:0]   eq;
  logic [NCH-1:0]   eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      eq_q    <= '0;
    end else begin
      count_q <= count;
      eq_q    <= eq;
    end
  end

  assign count_same = (count == count_q);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    assign eq[ch]   = (count == match_val[ch*CNT_W +: CNT_W]);
    // A match already seen on this very counter value is not acted on again.
    assign fire[ch] = eq[ch] & ~(eq_q[ch] & count_same);

    // R5: a held counter never produces a second event
    p_once_per_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire[ch] |=> !(fire[ch] && $stable(count)));
  end

endmodule

// File: rtl/match_channel.sv
module match_channel
  import match_output_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  act_e act,
  input  logic wr_en,
  input  logic wr_bit,
  output logic level
);

  logic acting;
  logic level_d;

  assign acting  = fire && (act != ACT_NONE);
  assign level_d = acting ? apply_action(act, level)
                 : (wr_en ? wr_bit : level);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= 1'b0;
    else        level <= level_d;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> !level);

  p_low_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_LOW) |=> !level);

  p_high_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_HIGH) |=> level);

  p_toggle_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_TGL) |=> level != $past(level));

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(fire && act != ACT_NONE)) |=> $stable(level));

  p_write_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(fire && act != ACT_NONE)) |=> level == $past(wr_bit));

endmodule

// File: rtl/match_output_ctrl.sv
module match_output_ctrl
  import match_output_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     count,
  input  logic [4*CNT_W-1:0]   match_val,
  input  logic                 reg_we,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic [3:0]           match_out
);

  logic [NCH-1:0]       fire;
  logic [NCH*ACT_W-1:0] act_q;
  logic [NCH-1:0]       level;
  logic                 unused_rsvd;

  assign unused_rsvd = ^reg_wdata[REG_W-1:RSVD_LSB];

  match_detect #(.CNT_W(CNT_W)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .match_val (match_val),
    .fire      (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      act_q <= '0;
    else if (reg_we) act_q <= reg_wdata[ACT_LSB +: NCH*ACT_W];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    match_channel u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire[ch]),
      .act    (act_e'(act_q[ch*ACT_W +: ACT_W])),
      .wr_en  (reg_we),
      .wr_bit (reg_wdata[STATE_LSB + ch]),
      .level  (level[ch])
    );
  end

  assign match_out = level;
  assign reg_rdata = {{RSVD_W{1'b0}}, act_q, level};

  p_act_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[RSVD_LSB-1:ACT_LSB] == $past(reg_wdata[RSVD_LSB-1:ACT_LSB]));

  p_act_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_rdata[RSVD_LSB-1:ACT_LSB]));

  p_rsvd_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[REG_W-1:RSVD_LSB] == '0);

endmodule

// File: tb/test_match_output_ctrl.sv
module test_match_output_ctrl;

  localparam int CNT_W = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [CNT_W-1:0]   count = '0;
  logic [4*CNT_W-1:0] match_val = '0;
  logic               reg_we = 1'b0;
  logic [15:0]        reg_wdata = '0;
  logic [15:0]        reg_rdata;
  logic [3:0]         match_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  match_output_ctrl #(.CNT_W(CNT_W)) i_match_output_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .match_val (match_val),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .match_out (match_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_match(input int m0, input int m1, input int m2, input int m3);
    match_val = {CNT_W'(m3), CNT_W'(m2), CNT_W'(m1), CNT_W'(m0)};
  endtask

  // Drive on a falling edge, let one rising edge pass, return on the next falling edge.
  task automatic step(input logic [CNT_W-1:0] cnt, input logic we, input logic [15:0] wd);
    count = cnt; reg_we = we; reg_wdata = wd;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(0, 1'b0, 16'h0);
    check("R1 rdata after reset", reg_rdata, 16'h0000);
    check("R1 outputs after reset", {12'h0, match_out}, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_write_read;
    set_match(1000, 1001, 1002, 1003);
    step(0, 1'b1, 16'hF0A5);
    check("R3 R7 rdata after write", reg_rdata, 16'h00A5);
    check("R8 outputs take written bits", {12'h0, match_out}, 16'h0005);
    check("R2 mirror", {12'h0, reg_rdata[3:0]}, {12'h0, match_out});
    step(0, 1'b1, 16'hFFFF);
    check("R7 reserved still 0", {12'h0, reg_rdata[15:12]}, 16'h0000);
    check("R3 all codes written", reg_rdata, 16'h0FFF);
  endtask

  task automatic t_actions;
    // ch0 toggle, ch1 low, ch2 high, ch3 none; levels 1010
    step(0, 1'b1, 16'h027A);
    check("R8 preset", reg_rdata, 16'h027A);
    set_match(5, 5, 5, 5);
    step(5, 1'b0, 16'h0);
    check("R4 per-code result", {12'h0, match_out}, 16'h000D);
    check("R2 mirror after match", reg_rdata, 16'h027D);
  endtask

  task automatic t_held;
    for (int i = 0; i < 4; i++) begin
      step(5, 1'b0, 16'h0);
      check("R5 held counter no repeat", {12'h0, match_out}, 16'h000D);
    end
    step(6, 1'b0, 16'h0);
    check("R5 off match", {12'h0, match_out}, 16'h000D);
    step(5, 1'b0, 16'h0);
    check("R5 rematch toggles again", {12'h0, match_out}, 16'h000C);
  endtask

  task automatic t_conflict;
    step(6, 1'b0, 16'h0);
    // Write levels 0000 and the same codes together with a match on all channels.
    step(5, 1'b1, 16'h0270);
    check("R6 match wins over write", {12'h0, match_out}, 16'h0005);
  endtask

  task automatic t_independent;
    set_match(10, 11, 12, 13);
    step(0, 1'b1, 16'h0FF0);
    check("R9 preset all toggle", reg_rdata, 16'h0FF0);
    for (int c = 10; c <= 13; c++) begin
      step(CNT_W'(c), 1'b0, 16'h0);
      check("R9 own channel only", {12'h0, match_out}, 16'((1 << (c - 9)) - 1));
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_write_read;
    t_actions;
    t_held;
    t_conflict;
    t_independent;
    step(0, 1'b1, 16'h0FFF);
    t_reset;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule